// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Two-Word Holding Buffer

This block recovers data words from an asynchronous serial line that idles high. A one-cycle oversampling strobe arrives sixteen times per bit period; the receiver watches for a low level, checks at the middle of that bit that it is a real start bit, then takes each data bit by majority vote around its centre, least significant bit first. An optional parity position is stepped over, and the stop bit is voted in the same way. A stop bit that votes low marks the word with a framing error, but the word is still stored.

Finished words go into a buffer that holds two entries, drained through a valid/ready output. The head entry is presented on `out_data` and `out_ferr` while `out_valid` is high. A word leaves on a clock edge where `out_valid` and `out_ready` are both high. `out_ready` may be held high permanently; holding it low stalls the head without limit and keeps it stable. If a third word completes while both entries are full, that word is dropped and a sticky overrun flag is raised. The flag stops all further reception until `rx_en` is taken low and back high. The line is expected to be synchronous to `clk` already; the strobe generator is outside the block.

Top module: `serial_rx_buf`

## Requirements
- R1: In idle, a low sample on a strobe starts a frame; if the line reads high on the 8th strobe of the start bit, the frame is abandoned and nothing is stored.
- R2: Each data bit is the majority of its 7th, 8th and 9th strobe samples, first bit received into bit 0 of `out_data`; a single wrong sample among those three does not change the bit.
- R3: `out_ferr` is 1 for a stored word whose stop bit voted low, and 0 when it voted high.
- R4: With `cfg_short` = 1 the frame carries 7 data bits and `out_data[7]` reads 0; with `cfg_par` = 1 one extra bit period after the data is skipped without affecting the word.
- R5: `out_valid` is 1 exactly while at least one word is held; a word is removed on an edge where `out_valid` and `out_ready` are both 1, and `out_ready` has no effect while `out_valid` is 0.
- R6: Words leave in arrival order; after the older of two is removed the newer one is presented and `out_valid` stays 1; while not removed the head stays stable.
- R7: A word completing while two words are held (and none is removed on that edge) is discarded and sets `ovr_err`; the held words are unchanged.
- R8: `ovr_err` stays set while `rx_en` is 1, blocks reception of new frames, and is 0 after any edge at which `rx_en` is 0.
- R9: Frames are received only while both `mod_en` and `rx_en` are 1.
- R10: Dropping `mod_en` or `rx_en` during a frame abandons it without storing anything and leaves the held words intact.
- R11: The receiver advances only on edges where `tick16` is 1; a low line without strobes starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling strobe, 16 per bit period |
| rxd | input | 1 | Serial line, idle high, already synchronous |
| mod_en | input | 1 | Block enable |
| rx_en | input | 1 | Receive enable; low also clears the overrun flag |
| cfg_short | input | 1 | 1: 7 data bits, 0: 8 data bits (static) |
| cfg_par | input | 1 | 1: a parity bit period follows the data (static) |
| out_valid | output | 1 | A word is held |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | 8 | Head word data |
| out_ferr | output | 1 | Head word framing error |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
A wrong fill count shows on `out_valid` on the very next clock, either as a missing flag after a stored word or as a flag that survives the last removal. A wrong slot shift shows as a repeated or skipped word at the next removal, and a mistimed bit counter or vote window shows as a wrong `out_data` bit or a false framing error as soon as the frame's stop decision is stored, about 8 strobes into the stop bit. Overrun state errors are visible at once on `ovr_err` and, while it is set, as frames that are or are not stored.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  parameter int unsigned RXW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic           ferr;
    logic [RXW-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     active,
  input  logic     rxd,
  input  logic     cfg_short,
  input  logic     cfg_par,
  output logic     done,
  output rx_word_t word
);
  localparam int unsigned DW = RXW;
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned BW = $clog2(DW);
  localparam logic [CW-1:0] MID   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] EARLY = CW'(OVS / 2 - 2);
  localparam logic [CW-1:0] LATE  = CW'(OVS / 2);
  localparam logic [CW-1:0] LAST  = CW'(OVS - 1);

  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] sh;
  logic          s_a, s_b;
  logic          vote;
  logic [BW-1:0] last_bit;

  assign vote     = (s_a & s_b) | (s_a & rxd) | (s_b & rxd);
  assign last_bit = cfg_short ? BW'(DW - 2) : BW'(DW - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      bidx <= '0;
      sh   <= '0;
      s_a  <= 1'b0;
      s_b  <= 1'b0;
    end else if (!active) begin
      st <= ST_IDLE;
    end else if (tick) begin
      if (st != ST_IDLE) cnt <= cnt + 1'b1;
      if (cnt == EARLY) s_a <= rxd;
      if (cnt == MID)   s_b <= rxd;
      case (st)
        ST_IDLE: begin
          if (!rxd) begin
            st  <= ST_START;
            cnt <= {{(CW-1){1'b0}}, 1'b1};
          end
        end
        ST_START: begin
          if (cnt == MID && rxd) st <= ST_IDLE;
          else if (cnt == LAST) begin
            st   <= ST_DATA;
            bidx <= '0;
          end
        end
        ST_DATA: begin
          if (cnt == LATE) sh <= {vote, sh[DW-1:1]};
          if (cnt == LAST) begin
            if (bidx == last_bit) st <= cfg_par ? ST_PAR : ST_STOP;
            else                  bidx <= bidx + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt == LAST) st <= ST_STOP;
        end
        ST_STOP: begin
          if (cnt == LATE) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign done      = active & tick & (st == ST_STOP) & (cnt == LATE);
  assign word.data = cfg_short ? {1'b0, sh[DW-1:1]} : sh;
  assign word.ferr = ~vote;
endmodule

// File: rtl/serial_rx_pair.sv
module serial_rx_pair
  import serial_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_word_t in_word,
  input  logic     rx_en,
  input  logic     pop_rdy,
  output logic     out_valid,
  output rx_word_t head,
  output logic     ovr
);
  logic [1:0] fill;
  rx_word_t   lo, hi;
  logic       full, pop, take;

  assign full = (fill == 2'd2);
  assign pop  = pop_rdy & (fill != 2'd0);
  assign take = push & ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= 2'd0;
      lo   <= '0;
      hi   <= '0;
      ovr  <= 1'b0;
    end else begin
      case ({pop, take})
        2'b10: begin
          lo   <= hi;
          fill <= fill - 1'b1;
        end
        2'b01: begin
          if (fill == 2'd0) lo <= in_word;
          else              hi <= in_word;
          fill <= fill + 1'b1;
        end
        2'b11: lo <= in_word;
        default: ;
      endcase
      if (!rx_en)           ovr <= 1'b0;
      else if (push & full) ovr <= 1'b1;
    end
  end

  assign out_valid = (fill != 2'd0);
  assign head      = lo;
endmodule

// File: rtl/serial_rx_buf.sv
module serial_rx_buf
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick16,
  input  logic           rxd,
  input  logic           mod_en,
  input  logic           rx_en,
  input  logic           cfg_short,
  input  logic           cfg_par,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [RXW-1:0] out_data,
  output logic           out_ferr,
  output logic           ovr_err
);
  logic     rx_active;
  logic     fr_done;
  rx_word_t fr_word;
  rx_word_t head;

  assign rx_active = mod_en & rx_en & ~ovr_err;

  serial_rx_frame #(.OVS(OVS)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .active    (rx_active),
    .rxd       (rxd),
    .cfg_short (cfg_short),
    .cfg_par   (cfg_par),
    .done      (fr_done),
    .word      (fr_word)
  );

  serial_rx_pair u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fr_done),
    .in_word   (fr_word),
    .rx_en     (rx_en),
    .pop_rdy   (out_ready),
    .out_valid (out_valid),
    .head      (head),
    .ovr       (ovr_err)
  );

  assign out_data = head.data;
  assign out_ferr = head.ferr;
endmodule

// File: rtl/serial_rx_buf_chk.sv
module serial_rx_buf_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mod_en,
  input logic          rx_en,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_ferr,
  input logic          ovr_err
);
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && rx_en) |=> ovr_err); // R8

  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !ovr_err); // R8

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ferr))); // R6

  AST_OVR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(out_valid)); // R7

  AST_RX_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(mod_en && rx_en)); // R9
endmodule

bind serial_rx_buf serial_rx_buf_chk #(.DW(serial_rx_pkg::RXW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mod_en    (mod_en),
  .rx_en     (rx_en),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_ferr  (out_ferr),
  .ovr_err   (ovr_err)
);

// File: tb/test_serial_rx_buf.sv
module test_serial_rx_buf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b1;
  logic       rxd = 1'b1;
  logic       mod_en = 1'b1;
  logic       rx_en = 1'b1;
  logic       cfg_short = 1'b0;
  logic       cfg_par = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ferr;
  logic       ovr_err;

  always #4 clk = ~clk;

  serial_rx_buf i_serial_rx_buf (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .mod_en(mod_en), .rx_en(rx_en), .cfg_short(cfg_short), .cfg_par(cfg_par),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_ferr(out_ferr), .ovr_err(ovr_err)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wd = 0;

  int pend_cyc[$];
  int pend_dat[$];
  int pend_fe[$];
  int q_dat[$];
  int q_fe[$];
  bit m_ovr = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Reference model: word queue plus overrun flag, updated on each edge
  always @(posedge clk) begin
    bit pop, full, pushnow;
    int pd, pf;
    cyc = cyc + 1;
    if (!rst_n) begin
      q_dat.delete(); q_fe.delete(); m_ovr = 1'b0;
    end else begin
      pop     = out_ready && (q_dat.size() > 0);
      full    = (q_dat.size() == 2);
      pushnow = (pend_cyc.size() > 0) && (pend_cyc[0] == cyc);
      pd = 0; pf = 0;
      if (pushnow) begin
        void'(pend_cyc.pop_front());
        pd = pend_dat.pop_front();
        pf = pend_fe.pop_front();
      end
      if (pop) begin
        void'(q_dat.pop_front());
        void'(q_fe.pop_front());
      end
      if (pushnow && !full) begin
        q_dat.push_back(pd);
        q_fe.push_back(pf);
      end
      if (!rx_en) m_ovr = 1'b0;
      else if (pushnow && full) m_ovr = 1'b1;
    end
  end

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(out_valid == (q_dat.size() > 0), "R5 valid", out_valid, q_dat.size() > 0);
      if (out_valid && q_dat.size() > 0) begin
        check(out_data == q_dat[0][7:0], "R2/R6 head data", out_data, q_dat[0]);
        check(out_ferr == q_fe[0][0], "R3 head ferr", out_ferr, q_fe[0]);
      end
      check(ovr_err == m_ovr, "R7/R8 overrun", ovr_err, m_ovr);
    end
  end

  // Send one frame; abort_at >= 0 drops rx_en at the start of that bit period
  task automatic send_frame(input int data, input bit short7, input bit par,
                            input bit stopv, input bit expect_rx,
                            input bit glitch, input int abort_at);
    int nb, s, t0, k;
    bit v;
    nb = short7 ? 7 : 8;
    s  = 1 + nb + (par ? 1 : 0);
    @(negedge clk);
    t0 = cyc + 1;
    if (expect_rx) begin
      pend_cyc.push_back(t0 + 16 * s + 8);
      pend_dat.push_back(data & (short7 ? 8'h7f : 8'hff));
      pend_fe.push_back(stopv ? 0 : 1);
    end
    for (k = 0; k <= s; k++) begin
      if (k == 0)       v = 1'b0;
      else if (k <= nb) v = data[k-1];
      else if (k == s)  v = stopv;
      else              v = ^data[7:0];
      for (int j = 0; j < 16; j++) begin
        if (k == abort_at && j == 0) rx_en = 1'b0;
        rxd = (glitch && k == 1 && j == 7) ? ~v : v;
        @(negedge clk);
      end
    end
    rxd = 1'b1;
    repeat (20) @(negedge clk);
    if (abort_at >= 0) rx_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_one();
    @(negedge clk) out_ready = 1'b1;
    @(negedge clk) out_ready = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R5 reset valid", out_valid, 0);
    check(ovr_err == 1'b0, "R8 reset overrun", ovr_err, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2: 8-bit word with one glitched sample inside the vote window
    send_frame(8'hA5, 0, 0, 1, 1, 1, -1);
    check(out_valid && out_data == 8'hA5, "R2 majority vote", out_data, 8'hA5);
    check(out_ferr == 1'b0, "R3 good stop", out_ferr, 0);
    pop_one();
    check(out_valid == 1'b0, "R5 empty after pop", out_valid, 0);

    // R4: 7 data bits with parity period
    cfg_short = 1'b1; cfg_par = 1'b1;
    send_frame(8'hDB, 1, 1, 1, 1, 0, -1);
    check(out_data == 8'h5B, "R4 short word", out_data, 8'h5B);
    pop_one();
    cfg_short = 1'b0; cfg_par = 1'b0;

    // R3: stop bit low
    send_frame(8'h3C, 0, 0, 0, 1, 0, -1);
    check(out_valid && out_ferr == 1'b1, "R3 framing error", out_ferr, 1);
    pop_one();

    // R1: short low pulse is rejected at mid start bit
    @(negedge clk) rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    check(out_valid == 1'b0, "R1 noise rejected", out_valid, 0);

    // R11: low line without strobes
    tick16 = 1'b0; rxd = 1'b0;
    repeat (30) @(negedge clk);
    rxd = 1'b1;
    repeat (2) @(negedge clk);
    tick16 = 1'b1;
    repeat (40) @(negedge clk);
    check(out_valid == 1'b0, "R11 no strobe no start", out_valid, 0);

    // R9: module disabled
    mod_en = 1'b0;
    send_frame(8'h77, 0, 0, 1, 0, 0, -1);
    check(out_valid == 1'b0, "R9 disabled", out_valid, 0);
    mod_en = 1'b1;

    // R10: abort keeps stored word
    send_frame(8'h11, 0, 0, 1, 1, 0, -1);
    send_frame(8'h99, 0, 0, 1, 0, 0, 4);
    check(out_valid && out_data == 8'h11, "R10 abort preserves", out_data, 8'h11);
    pop_one();

    // R7/R8/R6: overrun sequence
    send_frame(8'h01, 0, 0, 1, 1, 0, -1);
    send_frame(8'h02, 0, 0, 1, 1, 0, -1);
    send_frame(8'h03, 0, 0, 1, 1, 0, -1);
    check(ovr_err == 1'b1, "R7 overrun set", ovr_err, 1);
    check(out_data == 8'h01, "R7 held words kept", out_data, 8'h01);
    send_frame(8'h04, 0, 0, 1, 0, 0, -1);
    pop_one();
    check(out_valid && out_data == 8'h02, "R6 upper moves down", out_data, 8'h02);
    pop_one();
    check(out_valid == 1'b0, "R5 last read clears valid", out_valid, 0);
    check(ovr_err == 1'b1, "R8 overrun sticky", ovr_err, 1);
    @(negedge clk) rx_en = 1'b0;
    @(negedge clk) rx_en = 1'b1;
    @(negedge clk);
    check(ovr_err == 1'b0, "R8 overrun cleared", ovr_err, 0);
    send_frame(8'h05, 0, 0, 1, 1, 0, -1);
    check(out_valid && out_data == 8'h05, "R8 reception resumes", out_data, 8'h05);
    pop_one();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule